// File: doc/BRIEF.md
# Two-Stage In-Order Processor Core

This block is a minimal processor core with two pipeline stages. The first stage holds the program counter. It reads the instruction word at that address, decodes it, and reads its operands from the register file. It then places the decoded instruction into a one-entry holding slot. The second stage takes the instruction out of that slot. It performs an add, resolves a branch, or accesses data memory, and it writes any result back into the register file.

Instruction memory and data memory sit outside the core. Both are read combinationally from an address the core drives. Data memory is written on the clock edge while the core raises its write strobe.

Within a cycle, the execute stage acts first. It retires or squashes the held instruction and writes back its result. Only after that does decode search the slot for pending destinations and read its operands. A write to a register is therefore visible to a read of the same register in the same cycle. An instruction that is leaving the slot in the current cycle never holds up fetch.

The next fetch address is always the current one plus one. A taken branch overrides this with its target and discards the instruction fetched in that cycle.

Top module: `tsp_core`

## Requirements
- R1: Reset (active-low, asynchronous) sets the fetch address to 0, empties the holding slot and clears every register to zero. In the first cycle after reset the data-memory write strobe stays low whatever word sits at address 0.
- R2: An instruction is 17 bits wide. Bits [16:15] are the opcode: 00 add, 01 branch-if-zero, 10 load, 11 store. Bits [14:10], [9:5] and [4:0] are register fields A, B and C.
- R3: Add writes the sum of registers B and C, modulo 2^32, into register A.
- R4: Load writes into register A the data-memory word addressed by the low 5 bits of register B. Store writes register C to the data-memory word addressed by the low 5 bits of register B. The write strobe is high for exactly the one cycle in which the store executes.
- R5: Without a redirect, the fetch address advances by one every cycle. One instruction enters the holding slot per cycle.
- R6: An operand read in the same cycle as a write-back to that register returns the value being written. Reads of other registers return their stored contents. As a result, back-to-back dependent instructions compute correct results.
- R7: The search for pending destinations happens after the same-cycle retirement. A dependency on the instruction that is retiring in that cycle never stalls fetch.
- R8: A branch-if-zero is taken when register B equals zero. A taken branch loads the fetch address with the low 5 bits of register C. It also discards the instruction fetched in that cycle, which leaves no architectural effect. The next instruction to enter the slot is the one at the target.
- R9: A branch whose condition register is nonzero only retires. Fetch continues at the next sequential address.
- R10: After any program, the contents of data memory equal those produced by executing the same program one instruction at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 5 | Instruction fetch address (program counter) |
| imem_data | input | 17 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 5 | Data-memory address for load or store |
| dmem_rdata | input | 32 | Data word at dmem_addr, combinational |
| dmem_we | output | 1 | Data-memory write strobe, taken at the clock edge |
| dmem_wdata | output | 32 | Data to be stored |

## Verification
Errors in the program counter or in slot bookkeeping show up on imem_addr in the very next cycle. They appear as a repeated address (a spurious stall), a skipped address, or a missing redirect one cycle after a taken branch. Errors in forwarding, decode or write-back stay hidden until a later store exposes the affected register. The bench therefore ends every program by storing the values it computed, and it compares the whole data memory with an instruction-at-a-time model. A squashed instruction that wrongly survives shows up as a memory word that should never have been written.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
    localparam int unsigned XLEN  = 32;
    localparam int unsigned RIDX  = 5;
    localparam int unsigned AW    = 5;
    localparam int unsigned NREG  = 1 << RIDX;
    localparam int unsigned OPW   = 2;
    localparam int unsigned NFLD  = 3;
    localparam int unsigned IW    = OPW + NFLD * RIDX;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;
    typedef logic [AW-1:0]   addr_t;
    typedef logic [IW-1:0]   instr_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 2'b00,
        OP_BZ  = 2'b01,
        OP_LD  = 2'b10,
        OP_ST  = 2'b11
    } op_e;

    // decoded instruction held between the stages
    typedef struct packed {
        op_e   op;
        logic  wr;
        ridx_t dst;
        word_t va;
        word_t vb;
    } slot_t;

    function automatic op_e instr_op(instr_t i);
        return op_e'(i[IW-1 -: OPW]);
    endfunction

    // k = 0 -> field A, 1 -> field B, 2 -> field C
    function automatic ridx_t instr_fld(instr_t i, int unsigned k);
        return i[(NFLD-k)*RIDX-1 -: RIDX];
    endfunction
endpackage

// File: rtl/tsp_regfile.sv
module tsp_regfile import tsp_pkg::*; #(
    parameter int unsigned NRD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  ridx_t             waddr,
    input  word_t             wdata,
    input  ridx_t [NRD-1:0]   raddr,
    output word_t [NRD-1:0]   rdata
);
    typedef struct packed {
        word_t [NREG-1:0] r;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.r[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (we && (raddr[p] == waddr)) ? wdata : st_q.r[raddr[p]];

        // R6
        fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(we) && !we && (raddr[p] == $past(waddr))) |-> (rdata[p] == $past(wdata)));
    end
endmodule

// File: rtl/tsp_slotbuf.sv
module tsp_slotbuf import tsp_pkg::*; #(
    parameter int unsigned NKEY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq,
    input  slot_t             enq_slot,
    input  logic              deq,
    input  logic              clr,
    input  ridx_t [NKEY-1:0]  key,
    output logic              full,
    output slot_t             head,
    output logic              hit
);
    typedef struct packed {
        logic  full;
        slot_t slot;
    } buf_t;

    buf_t st_d, st_q;
    logic [NKEY-1:0] match;

    always_comb begin
        st_d = st_q;
        if (deq) st_d.full = 1'b0;
        if (enq) begin
            st_d.full = 1'b1;
            st_d.slot = enq_slot;
        end
        if (clr) st_d.full = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < NKEY; k++) begin : g_key
        assign match[k] = (st_q.slot.dst == key[k]);
    end

    // search sees the slot as it stands after this cycle's retirement
    assign hit  = st_q.full && !deq && st_q.slot.wr && (|match);
    assign full = st_q.full;
    assign head = st_q.slot;

    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !full);

    // R5
    enq_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq |-> (!full || deq));

    // R5
    enq_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq && !clr) |=> (full && (head == $past(enq_slot))));
endmodule

// File: rtl/tsp_fetch.sv
module tsp_fetch import tsp_pkg::*; #(
    parameter int unsigned NSRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  instr_t            instr,
    input  word_t [NSRC-1:0]  src_val,
    input  logic              hit,
    input  logic              space,
    input  logic              redirect,
    input  addr_t             target,
    output addr_t             pc,
    output ridx_t [NSRC-1:0]  src,
    output logic              enq,
    output slot_t             slot
);
    typedef struct packed {
        addr_t pc;
    } fs_t;

    fs_t st_d, st_q;
    op_e op;

    assign op = instr_op(instr);

    always_comb begin
        src[0] = instr_fld(instr, 1);
        src[1] = (op == OP_LD) ? instr_fld(instr, 1) : instr_fld(instr, 2);

        slot.op  = op;
        slot.wr  = (op == OP_ADD) || (op == OP_LD);
        slot.dst = instr_fld(instr, 0);
        slot.va  = src_val[0];
        slot.vb  = src_val[1];

        enq = space && !hit && !redirect;

        st_d = st_q;
        if (redirect)  st_d.pc = target;
        else if (enq)  st_d.pc = st_q.pc + addr_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc = st_q.pc;

    // R5
    seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq |=> (pc == $past(pc) + addr_t'(1)));

    // R8
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (pc == $past(target)));
endmodule

// File: rtl/tsp_exec.sv
module tsp_exec import tsp_pkg::*; (
    input  logic   full,
    input  slot_t  head,
    input  word_t  dmem_rdata,
    output logic   deq,
    output logic   clr,
    output logic   redirect,
    output addr_t  target,
    output logic   rf_we,
    output ridx_t  rf_waddr,
    output word_t  rf_wdata,
    output addr_t  dmem_addr,
    output logic   dmem_we,
    output word_t  dmem_wdata
);
    logic taken;

    always_comb begin
        taken      = full && (head.op == OP_BZ) && (head.va == '0);
        clr        = taken;
        redirect   = taken;
        deq        = full && !taken;
        target     = head.vb[AW-1:0];

        rf_we      = full && head.wr;
        rf_waddr   = head.dst;
        rf_wdata   = (head.op == OP_LD) ? dmem_rdata : (head.va + head.vb);

        dmem_addr  = head.va[AW-1:0];
        dmem_we    = full && (head.op == OP_ST);
        dmem_wdata = head.vb;
    end
endmodule

// File: rtl/tsp_core.sv
module tsp_core import tsp_pkg::*; (
    input  logic            clk,
    input  logic            rst_n,
    output logic [AW-1:0]   imem_addr,
    input  logic [IW-1:0]   imem_data,
    output logic [AW-1:0]   dmem_addr,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            dmem_we,
    output logic [XLEN-1:0] dmem_wdata
);
    localparam int unsigned NSRC = 2;

    ridx_t [NSRC-1:0] src;
    word_t [NSRC-1:0] src_val;
    logic  hit, full, deq, clr, redirect, enq, rf_we, space;
    addr_t target;
    slot_t slot, head;
    ridx_t rf_waddr;
    word_t rf_wdata;

    assign space = !full || deq;

    tsp_fetch #(.NSRC(NSRC)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr    (imem_data),
        .src_val  (src_val),
        .hit      (hit),
        .space    (space),
        .redirect (redirect),
        .target   (target),
        .pc       (imem_addr),
        .src      (src),
        .enq      (enq),
        .slot     (slot)
    );

    tsp_regfile #(.NRD(NSRC)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (src),
        .rdata (src_val)
    );

    tsp_slotbuf #(.NKEY(NSRC)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .enq      (enq),
        .enq_slot (slot),
        .deq      (deq),
        .clr      (clr),
        .key      (src),
        .full     (full),
        .head     (head),
        .hit      (hit)
    );

    tsp_exec u_exec (
        .full       (full),
        .head       (head),
        .dmem_rdata (dmem_rdata),
        .deq        (deq),
        .clr        (clr),
        .redirect   (redirect),
        .target     (target),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .dmem_addr  (dmem_addr),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata)
    );

    // R4
    st_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> $past(enq));

    // R7
    retire_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !redirect) |-> enq);
endmodule

// File: tb/tsp_core_test.sv
`timescale 1ns/1ps
module tsp_core_test;
    import tsp_pkg::*;

    localparam int DEPTH = 1 << AW;
    localparam int NPROG = 2;
    localparam int PLEN  = 20;
    localparam int TLEN  = 14;
    localparam int NRUN  = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0]   imem_addr, dmem_addr;
    logic [IW-1:0]   imem_data;
    logic [XLEN-1:0] dmem_rdata, dmem_wdata;
    logic            dmem_we;

    logic [IW-1:0]   imem [DEPTH];
    logic [XLEN-1:0] dmem [DEPTH];
    logic [XLEN-1:0] ref_mem [DEPTH];

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    tsp_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata)
    );

    int checks = 0;
    int fails  = 0;

    // R2 encodings
    function automatic logic [16:0] enc(logic [1:0] op, int a, int b, int c);
        logic [4:0] fa = a[4:0];
        logic [4:0] fb = b[4:0];
        logic [4:0] fc = c[4:0];
        return {op, fa, fb, fc};
    endfunction
    function automatic logic [16:0] I_ADD(int d, int s1, int s2); return enc(2'b00, d, s1, s2); endfunction
    function automatic logic [16:0] I_BZ(int cnd, int tgt);       return enc(2'b01, 0, cnd, tgt); endfunction
    function automatic logic [16:0] I_LD(int d, int a);           return enc(2'b10, d, a, 0);     endfunction
    function automatic logic [16:0] I_ST(int a, int v);           return enc(2'b11, 0, a, v);     endfunction

    localparam logic [16:0] HALT = I_BZ(0, 9);

    localparam logic [16:0] PROG [NPROG][PLEN] = '{
        '{ I_LD(9,0),  I_LD(1,9),  I_ADD(2,1,1), I_ADD(3,2,1), I_ADD(5,3,3),
           I_ADD(5,5,2), I_LD(6,5), I_ADD(7,6,6), I_ST(3,7),   I_LD(8,3),
           I_ADD(8,8,1), I_ST(5,8), I_ST(2,6),   I_ADD(3,3,3), I_ST(3,9),
           I_BZ(0,9),  HALT,       HALT,         HALT,         HALT },
        '{ I_LD(9,0),  I_LD(1,9),  I_ADD(2,1,1), I_ADD(4,2,2), I_ADD(7,4,4),
           I_BZ(0,7),  I_ST(1,9),  I_ST(2,9),    I_BZ(1,7),    I_ST(4,7),
           I_ADD(3,0,0), I_ADD(10,7,7), I_BZ(3,10), I_ST(0,7),  I_ST(1,7),
           HALT,       I_ST(2,10), I_LD(11,7),   I_ST(10,11),  I_BZ(11,9) }
    };

    // expected fetch address for the first TLEN cycles after reset
    localparam int TRACE [NPROG][TLEN] = '{
        '{ 0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13 },
        '{ 0, 1, 2, 3, 4, 5, 6, 8, 9, 10, 11, 12, 13, 16 }
    };

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] mem_init(int i);
        if (i == 0)  return 32'd31;
        if (i == 31) return 32'd1;
        if (i < 8)   return XLEN'(i);
        return XLEN'(i) * 32'h0100_0193 + 32'd7;
    endfunction

    task automatic load_prog(int p);
        for (int i = 0; i < DEPTH; i++) begin
            imem[i]    = (i < PLEN) ? PROG[p][i] : HALT;
            dmem[i]    = mem_init(i);
            ref_mem[i] = mem_init(i);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(imem_addr == '0, "R1 pc in reset", imem_addr, 0);
        chk(dmem_we == 1'b0, "R1 no write in reset", dmem_we, 0);
        rst_n = 1'b1;
    endtask

    // instruction-at-a-time model (R10)
    task automatic run_model();
        logic [XLEN-1:0] rf [DEPTH];
        logic [AW-1:0]   pc = '0;
        for (int i = 0; i < DEPTH; i++) rf[i] = '0;
        for (int s = 0; s < 300; s++) begin
            logic [16:0] w  = imem[pc];
            logic [4:0]  fa = w[14:10];
            logic [4:0]  fb = w[9:5];
            logic [4:0]  fc = w[4:0];
            case (w[16:15])
                2'b00: begin rf[fa] = rf[fb] + rf[fc]; pc = pc + 1'b1; end
                2'b01: pc = (rf[fb] == '0) ? rf[fc][AW-1:0] : pc + 1'b1;
                2'b10: begin rf[fa] = ref_mem[rf[fb][AW-1:0]]; pc = pc + 1'b1; end
                default: begin ref_mem[rf[fb][AW-1:0]] = rf[fc]; pc = pc + 1'b1; end
            endcase
        end
    endtask

    task automatic run_prog(int p);
        load_prog(p);
        apply_reset();
        for (int c = 0; c < NRUN; c++) begin
            if (c == 0)
                chk(dmem_we == 1'b0, "R1 slot empty after reset", dmem_we, 0);
            if (c < TLEN)
                chk(imem_addr == AW'(TRACE[p][c]),
                    (p == 0) ? "R5/R7 fetch advance" : "R8/R9 fetch redirect",
                    imem_addr, TRACE[p][c]);
            if (dmem_we) dmem[dmem_addr] = dmem_wdata;
            @(negedge clk);
        end
        run_model();
        for (int i = 0; i < DEPTH; i++)
            chk(dmem[i] == ref_mem[i], "R10 memory vs model (R3 R4 R6)", dmem[i], ref_mem[i]);
    endtask

    initial begin
        #100_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < NPROG; p++) run_prog(p);
        // R8: squashed store at address 6 of the second program must not write word 1
        chk(dmem[1] == 32'd1, "R8 squashed store", dmem[1], 1);
        // R1: reset in the middle of a run
        rst_n = 1'b0;
        @(negedge clk);
        chk(imem_addr == '0, "R1 mid-run reset pc", imem_addr, 0);
        chk(dmem_we == 1'b0, "R1 mid-run reset write", dmem_we, 0);
        rst_n = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule